// File: doc/BRIEF.md
# Traffic-Adaptive Processing-Element Shutdown Controller

This controller watches the pool of idle packet-processing threads in a multi-core packet engine and decides when one processing element can be parked and when one must be brought back. Every cycle it compares the length of the idle-thread queue with the number of threads that a single element carries. It counts the cycles in which the queue holds at least that many, over a fixed observation window. When a window closes with more such cycles than a threshold allows, one element is surplus and the controller issues a one-cycle deactivation request.

Receive-buffer pressure works the other way. A new assertion of the buffer-full flag produces a one-cycle reactivation request straight away, without waiting for the window to close. The threshold either follows a configuration value (static mode) or adapts by itself (dynamic mode). In dynamic mode it creeps down after every calm window and steps up on each buffer-full event. A separate on/off sequencer consumes the requests. It reports back whether the smallest allowed set of elements is running and whether every element is running, and the controller holds back requests that would be pointless in those states. All pins are plain control and status levels or pulses. There is no streamed data and no handshake: a request pulse is not held or repeated, and the sequencer must accept it in the cycle it appears.

Top module: `pe_throttle_ctrl`

## Requirements
- R1: A cycle is a hit when `qlen_i >= tpe_i` (unsigned). The window is WIN_CYCLES cycles long, with the first window starting in the first clock after reset release. In the clock after a window's last cycle, `pe_off_req_o` pulses for one cycle when the window's hit count, including its last cycle, is strictly greater than the threshold in force during that last cycle.
- R2: The hit count restarts from zero for every window, so hits from earlier windows never add to a later decision.
- R3: After reset no request is active and the threshold equals WIN_CYCLES/2.
- R4: In dynamic mode (`dyn_mode_i`=1), a window in which `rbuf_full_i` was never high lowers the threshold at its end by max(1, floor(th/STEP_DIV)), where STEP_DIV defaults to 50 (2%).
- R5: In dynamic mode, each rising edge of `rbuf_full_i` raises the threshold by max(1, floor(th/STEP_DIV)) in the same clock. A window that saw the flag high in any cycle is not lowered at its end.
- R6: A rising edge of `rbuf_full_i` produces a one-cycle `pe_on_req_o` pulse in the next clock, at any point in the window.
- R7: In static mode (`dyn_mode_i`=0) the threshold takes the clamped `static_th_i` one clock later and buffer-full events do not change it.
- R8: The threshold always lies in 1..WIN_CYCLES-1. A static value of 0 gives 1, and a static value above WIN_CYCLES-1 gives WIN_CYCLES-1.
- R9: A deactivation is dropped when `at_min_i` is high in the window's last cycle. A reactivation is dropped when `all_on_i` is high in the rising-edge cycle.
- R10: When a buffer-full rising edge falls in a window's last cycle, no deactivation is issued for that window, even if the reactivation itself is suppressed.
- R11: `pe_off_req_o` and `pe_on_req_o` are never high together, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qlen_i | input | QLEN_W | Current idle-thread queue length |
| tpe_i | input | TPE_W | Threads per processing element |
| rbuf_full_i | input | 1 | Receive buffer full flag |
| dyn_mode_i | input | 1 | 1 = self-adjusting threshold, 0 = static threshold |
| static_th_i | input | CNT_W | Threshold value used in static mode |
| at_min_i | input | 1 | Sequencer: minimum element set active |
| all_on_i | input | 1 | Sequencer: every element active |
| pe_off_req_o | output | 1 | One-cycle request to park one element |
| pe_on_req_o | output | 1 | One-cycle request to wake one element |
| th_o | output | CNT_W | Threshold currently in force |

## Verification
The assertions check on every cycle that the threshold stays within its range, that the hit count never runs ahead of the cycles elapsed in the window, and that the two request pulses are exclusive and single-cycle. They also check that each pulse traces back to its cause: a window end without the minimum flag, or a buffer-full edge without the all-on flag, with no deactivation in an edge cycle. Only the bench scenarios show the exact step sizes of the adaptive threshold across a sequence of windows, the strict comparison at a hit count equal to the threshold, the exclusion of a queue one short of a full element, and the clamping of out-of-range static values.

// File: rtl/pe_thr_pkg.sv
package pe_thr_pkg;
  typedef enum logic [1:0] {
    ST_WATCH = 2'd0,
    ST_OFF   = 2'd1,
    ST_ON    = 2'd2
  } req_state_e;
endpackage

// File: rtl/window_tracker.sv
module window_tracker #(
  parameter int unsigned WIN_CYCLES = 1000000,
  parameter int unsigned QLEN_W     = 8,
  parameter int unsigned TPE_W      = 4,
  parameter int unsigned CNT_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QLEN_W-1:0] qlen_i,
  input  logic [TPE_W-1:0]  tpe_i,
  output logic              win_end_o,
  output logic [CNT_W-1:0]  hit_total_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] HIT_CAP  = CNT_W'(WIN_CYCLES);

  logic [CNT_W-1:0] win_cnt_q;
  logic [CNT_W-1:0] hit_cnt_q;
  logic [CNT_W-1:0] hit_sum;
  logic             hit;

  // A cycle counts when one whole element's worth of threads sits idle.
  assign hit       = (qlen_i >= QLEN_W'(tpe_i));
  assign win_end_o = (win_cnt_q == LAST_IDX);
  assign hit_sum   = (hit_cnt_q == HIT_CAP) ? HIT_CAP : (hit_cnt_q + CNT_W'(hit));
  assign hit_total_o = hit_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt_q <= '0;
      hit_cnt_q <= '0;
    end else if (win_end_o) begin
      win_cnt_q <= '0;
      hit_cnt_q <= '0;
    end else begin
      win_cnt_q <= win_cnt_q + 1'b1;
      hit_cnt_q <= hit_sum;
    end
  end

  // R1: hits in a window can never exceed the cycles elapsed in it
  p_hit_le_elapsed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cnt_q <= win_cnt_q);

  // R2: a closed window leaves nothing behind for the next one
  p_window_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_end_o |=> (hit_cnt_q == '0));
endmodule

// File: rtl/threshold_unit.sv
module threshold_unit #(
  parameter int unsigned WIN_CYCLES = 1000000,
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned STEP_DIV   = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dyn_mode_i,
  input  logic [CNT_W-1:0] static_th_i,
  input  logic             full_rise_i,
  input  logic             full_seen_i,
  input  logic             win_end_i,
  output logic [CNT_W-1:0] th_o
);
  localparam logic [CNT_W-1:0] TH_MAX  = CNT_W'(WIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] TH_MIN  = CNT_W'(1);
  localparam int unsigned      HALF    = WIN_CYCLES / 2;
  localparam logic [CNT_W-1:0] TH_INIT = (HALF < 1) ? CNT_W'(1) : CNT_W'(HALF);

  logic [CNT_W-1:0] th_q;
  logic [CNT_W-1:0] step_raw;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] th_up;
  logic [CNT_W-1:0] th_dn;
  logic [CNT_W-1:0] th_static;
  logic [CNT_W-1:0] th_d;

  assign step_raw = th_q / CNT_W'(STEP_DIV);
  assign step     = (step_raw == '0) ? TH_MIN : step_raw;
  assign th_up    = (th_q > (TH_MAX - step)) ? TH_MAX : (th_q + step);
  assign th_dn    = (th_q <= step) ? TH_MIN : (th_q - step);

  always_comb begin
    if (static_th_i < TH_MIN)       th_static = TH_MIN;
    else if (static_th_i > TH_MAX)  th_static = TH_MAX;
    else                            th_static = static_th_i;
  end

  always_comb begin
    th_d = th_q;
    if (!dyn_mode_i)                     th_d = th_static;
    else if (full_rise_i)                th_d = th_up;
    else if (win_end_i && !full_seen_i)  th_d = th_dn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) th_q <= TH_INIT;
    else        th_q <= th_d;
  end

  assign th_o = th_q;

  // R8: threshold confined to 1..WIN_CYCLES-1
  p_th_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (th_q >= TH_MIN) && (th_q <= TH_MAX));

  // R5: a buffer-full edge in dynamic mode never lowers the threshold
  p_raise_on_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dyn_mode_i && full_rise_i) |=> (th_q >= $past(th_q)));

  // R4: a calm window end in dynamic mode never raises the threshold
  p_lower_when_calm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dyn_mode_i && win_end_i && !full_seen_i) |=> (th_q <= $past(th_q)));

  // R5: with the flag seen in the window, the window end does not lower it
  p_no_lower_after_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dyn_mode_i && win_end_i && full_seen_i) |=> (th_q >= $past(th_q)));
endmodule

// File: rtl/decide_fsm.sv
module decide_fsm
  import pe_thr_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end_i,
  input  logic [CNT_W-1:0] hit_total_i,
  input  logic [CNT_W-1:0] th_i,
  input  logic             rbuf_full_i,
  input  logic             at_min_i,
  input  logic             all_on_i,
  output logic             full_rise_o,
  output logic             full_seen_o,
  output logic             off_req_o,
  output logic             on_req_o
);
  req_state_e state_q, state_d;
  logic       full_q;
  logic       seen_q;
  logic       surplus;

  assign full_rise_o = rbuf_full_i && !full_q;
  assign full_seen_o = seen_q || rbuf_full_i;
  assign surplus     = win_end_i && (hit_total_i > th_i);

  always_comb begin
    state_d = ST_WATCH;
    if (full_rise_o) begin
      // buffer pressure wins over any surplus seen in the same cycle
      if (!all_on_i) state_d = ST_ON;
    end else if (surplus && !at_min_i) begin
      state_d = ST_OFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_WATCH;
      full_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      full_q  <= rbuf_full_i;
      if (win_end_i)        seen_q <= 1'b0;
      else if (rbuf_full_i) seen_q <= 1'b1;
    end
  end

  assign off_req_o = (state_q == ST_OFF);
  assign on_req_o  = (state_q == ST_ON);

  // R11: requests exclusive
  p_req_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({off_req_o, on_req_o}));

  // R11: deactivation is a single-cycle pulse
  p_off_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    off_req_o |=> !off_req_o);

  // R6, R9: reactivation traces to an edge while not all elements run
  p_on_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    on_req_o |-> ($past(rbuf_full_i) && !$past(full_q) && !$past(all_on_i)));

  // R1, R9: deactivation only at a window end and never at minimum
  p_off_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    off_req_o |-> ($past(win_end_i) && !$past(at_min_i)));

  // R10: no deactivation for a window whose last cycle saw a full edge
  p_pressure_blocks_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end_i && full_rise_o) |=> !off_req_o);
endmodule

// File: rtl/pe_throttle_ctrl.sv
module pe_throttle_ctrl #(
  parameter int unsigned WIN_CYCLES = 1000000,
  parameter int unsigned QLEN_W     = 8,
  parameter int unsigned TPE_W      = 4,
  parameter int unsigned STEP_DIV   = 50,
  localparam int unsigned CNT_W     = $clog2(WIN_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QLEN_W-1:0] qlen_i,
  input  logic [TPE_W-1:0]  tpe_i,
  input  logic              rbuf_full_i,
  input  logic              dyn_mode_i,
  input  logic [CNT_W-1:0]  static_th_i,
  input  logic              at_min_i,
  input  logic              all_on_i,
  output logic              pe_off_req_o,
  output logic              pe_on_req_o,
  output logic [CNT_W-1:0]  th_o
);
  logic             win_end;
  logic [CNT_W-1:0] hit_total;
  logic             full_rise;
  logic             full_seen;
  logic [CNT_W-1:0] th;

  window_tracker #(
    .WIN_CYCLES (WIN_CYCLES),
    .QLEN_W     (QLEN_W),
    .TPE_W      (TPE_W),
    .CNT_W      (CNT_W)
  ) u_window (
    .clk         (clk),
    .rst_n       (rst_n),
    .qlen_i      (qlen_i),
    .tpe_i       (tpe_i),
    .win_end_o   (win_end),
    .hit_total_o (hit_total)
  );

  threshold_unit #(
    .WIN_CYCLES (WIN_CYCLES),
    .CNT_W      (CNT_W),
    .STEP_DIV   (STEP_DIV)
  ) u_thresh (
    .clk         (clk),
    .rst_n       (rst_n),
    .dyn_mode_i  (dyn_mode_i),
    .static_th_i (static_th_i),
    .full_rise_i (full_rise),
    .full_seen_i (full_seen),
    .win_end_i   (win_end),
    .th_o        (th)
  );

  decide_fsm #(
    .CNT_W (CNT_W)
  ) u_decide (
    .clk         (clk),
    .rst_n       (rst_n),
    .win_end_i   (win_end),
    .hit_total_i (hit_total),
    .th_i        (th),
    .rbuf_full_i (rbuf_full_i),
    .at_min_i    (at_min_i),
    .all_on_i    (all_on_i),
    .full_rise_o (full_rise),
    .full_seen_o (full_seen),
    .off_req_o   (pe_off_req_o),
    .on_req_o    (pe_on_req_o)
  );

  assign th_o = th;
endmodule

// File: tb/pe_throttle_ctrl_bench.sv
module pe_throttle_ctrl_bench;
  localparam int P     = 1000;
  localparam int QW    = 8;
  localparam int TW    = 4;
  localparam int CW    = $clog2(P + 1);
  localparam int TPE   = 4;
  localparam int K_OFF = 1;
  localparam int K_ON  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [QW-1:0] qlen_i = '0;
  logic [TW-1:0] tpe_i = TW'(TPE);
  logic          rbuf_full_i = 1'b0;
  logic          dyn_mode_i = 1'b1;
  logic [CW-1:0] static_th_i = '0;
  logic          at_min_i = 1'b0;
  logic          all_on_i = 1'b0;
  logic          pe_off_req_o, pe_on_req_o;
  logic [CW-1:0] th_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int model_th = P / 2;
  bit mon_en = 1'b0;
  bit finished = 1'b0;
  int    exp_kind[$];
  int    exp_due[$];
  string exp_req[$];

  always #4 clk = ~clk;

  pe_throttle_ctrl #(.WIN_CYCLES(P), .QLEN_W(QW), .TPE_W(TW)) u_pe_throttle_ctrl (
    .clk(clk), .rst_n(rst_n), .qlen_i(qlen_i), .tpe_i(tpe_i),
    .rbuf_full_i(rbuf_full_i), .dyn_mode_i(dyn_mode_i), .static_th_i(static_th_i),
    .at_min_i(at_min_i), .all_on_i(all_on_i),
    .pe_off_req_o(pe_off_req_o), .pe_on_req_o(pe_on_req_o), .th_o(th_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int step_of(input int th);
    int s;
    s = th / 50;
    return (s < 1) ? 1 : s;
  endfunction

  function automatic int clamp_th(input int v);
    if (v < 1) return 1;
    if (v > P - 1) return P - 1;
    return v;
  endfunction

  task automatic expect_pulse(input int kind, input string req);
    exp_kind.push_back(kind);
    exp_due.push_back(cyc + 1);
    exp_req.push_back(req);
  endtask

  // Scoreboard monitor: every pulse must match the head of the queue.
  always @(negedge clk) begin
    if (mon_en) begin
      int kind;
      kind = pe_off_req_o ? K_OFF : (pe_on_req_o ? K_ON : 0);
      if (pe_off_req_o && pe_on_req_o) check(1'b0, "R11 both requests", 3, 0);
      if (kind != 0) begin
        if (exp_kind.size() == 0) begin
          check(1'b0, "R11 unexpected request", kind, 0);
        end else begin
          check(exp_kind[0] == kind && exp_due[0] == cyc, exp_req[0], kind, exp_kind[0]);
          void'(exp_kind.pop_front()); void'(exp_due.pop_front()); void'(exp_req.pop_front());
        end
      end else if (exp_due.size() > 0 && exp_due[0] <= cyc) begin
        check(1'b0, exp_req[0], 0, exp_kind[0]);
        void'(exp_kind.pop_front()); void'(exp_due.pop_front()); void'(exp_req.pop_front());
      end
    end
  end

  // One full window; the driver predicts every request and the threshold.
  task automatic run_window(input int hits, input int full_at, input bit amin,
                            input bit allon, input bit dyn, input int sth,
                            input string tag);
    bit rose_last;
    bit saw_full;
    int th_end;
    saw_full = 1'b0;
    for (int i = 0; i < P; i++) begin
      if (i == 0) check(int'(th_o) == model_th, {tag, " threshold"}, int'(th_o), model_th);
      dyn_mode_i  = dyn;
      static_th_i = CW'(sth);
      qlen_i      = (i < hits) ? QW'(TPE) : QW'(i % TPE);
      rbuf_full_i = (i == full_at);
      at_min_i    = amin;
      all_on_i    = allon;
      rose_last   = 1'b0;
      if (i == full_at) begin
        saw_full = 1'b1;
        if (dyn) model_th = clamp_th(model_th + step_of(model_th));
        if (!allon) expect_pulse(K_ON, {tag, " R6 reactivation"});
        if (i == P - 1) rose_last = 1'b1;
      end
      if (i == P - 1) begin
        th_end = dyn ? model_th : clamp_th(sth);
        if (!rose_last && hits > th_end && !amin)
          expect_pulse(K_OFF, {tag, " R1 deactivation"});
      end
      @(negedge clk);
    end
    if (dyn) begin
      if (!saw_full) model_th = clamp_th(model_th - step_of(model_th));
    end else begin
      model_th = clamp_th(sth);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(th_o == CW'(P / 2), "R3 reset threshold", int'(th_o), P / 2);
    check(pe_off_req_o == 1'b0, "R3 reset off request", int'(pe_off_req_o), 0);
    check(pe_on_req_o == 1'b0, "R3 reset on request", int'(pe_on_req_o), 0);
    rst_n  = 1'b1;
    mon_en = 1'b1;
    // dynamic mode
    run_window(600, -1, 0, 0, 1, 0, "W1 R1 R4");          // surplus, lower
    run_window(495, -1, 1, 0, 1, 0, "W2 R9 R2");          // surplus held back at minimum
    run_window(481, -1, 0, 0, 1, 0, "W3 R1 equal");       // count equal to threshold
    run_window(0, 200, 0, 0, 1, 0, "W4 R5 R6");           // full edge mid-window
    run_window(0, 350, 0, 1, 1, 0, "W5 R9 R5");           // all on: edge raises only
    run_window(0, -1, 0, 0, 1, 0, "W6 R1 below T");       // queue one short of T
    run_window(P, P - 1, 0, 0, 1, 0, "W7 R10");           // edge in last cycle
    // static mode
    run_window(2, -1, 0, 0, 0, 0, "W8 R7 R8 low");        // static 0 clamps to 1
    run_window(P, -1, 0, 0, 0, 1010, "W9 R7 R8 high");    // static clamps to P-1
    run_window(0, 300, 0, 0, 0, 1010, "W10 R7 R6");       // full edge: no adaptation
    check(int'(th_o) == model_th, "R7 final threshold", int'(th_o), model_th);
    qlen_i = '0;
    rbuf_full_i = 1'b0;
    repeat (4) @(negedge clk);
    check(exp_kind.size() == 0, "R1 R6 pending expectations", exp_kind.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule